// File: doc/BRIEF.md
# Watermarked Port Credit Pool Manager

This block keeps track of how many events each port may still enqueue. There is a shared credit pool, and each port also holds a local stock of credits. Every accepted enqueue spends one local credit. A request from a port whose stock is empty is refused and changes nothing. When a port's stock drops to its low watermark, the block tops it up from the shared pool in fixed quanta. Credits handed back as events are scheduled always return to the shared pool.

The watermarks come from each port's configured enqueue depth:

- The high watermark equals the depth.
- The quantum is half the high watermark, rounded down.
- The low watermark is the smaller of 16 and the quantum.

A start pulse loads the configuration. It pre-charges every port to its high watermark out of the pool, so the shared level begins at the pool size minus the sum of the port depths.

An optional dual mode adds a second pool for directed traffic. Its size is either a given override or, when the override is zero, a quarter of the main pool size. Each port's directed high watermark is the smaller of its depth and the directed pool size divided by the port count. The configuration must give pools at least as large as the credits pre-charged out of them.

Top module: `credit_pool_mgr`

## Requirements
- R1: After reset, and until the first start pulse, both pool levels and all port credits read 0, no enqueue is accepted, and every request is answered with a reject.
- R2: One cycle after a start pulse, each port's load-balanced credits equal its depth, and the load-balanced pool equals the pool size minus the sum of the depths (four ports of 32 with a pool of 4096 leave 3968).
- R3: An accepted enqueue is signalled in the same cycle as the request. It lowers that port's credit count by exactly one at the next clock edge and leaves the pool unchanged.
- R4: A request from a port with zero credits in the pool it draws from is rejected in the same cycle. Its credit count and the pool level stay unchanged.
- R5: A port whose credits are at or below its low watermark, min(16, depth/2), has its stock raised by one quantum, depth/2, when the pool holds at least that quantum. The pool drops by the same amount, and both changes take effect at the clock edge after the condition holds.
- R6: While the pool holds less than a needy port's quantum, that port is not refilled. The refill happens at the edge after returns bring the pool up to the quantum.
- R7: When several ports need a refill in the same cycle, one port per pool is refilled per cycle. Ports are chosen round-robin in ascending index order, starting from port 0 after each start pulse and continuing from the port after the last one refilled.
- R8: A port's credit count never exceeds its high watermark in either pool.
- R9: Each cycle with ret_valid high adds one credit to a pool at the next edge. The credit goes to the directed pool when dual mode is on and ret_dir is 1; otherwise it goes to the load-balanced pool.
- R10: In dual mode the directed pool size is the override input when that input is nonzero, and the main pool size divided by 4 when it is zero. Each port's directed credits start at min(depth, directed size / number of ports), and the directed pool starts at the directed size minus the sum of those values.
- R11: In dual mode a request with enq_dir=1 spends only directed credits, and one with enq_dir=0 spends only load-balanced credits. In single mode enq_dir is ignored, every enqueue spends load-balanced credits, and directed credits and the directed pool stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Pulse: latch configuration and pre-charge ports |
| cfg_dual | input | 1 | Enable separate directed pool |
| cfg_pool_size | input | POOL_W | Load-balanced pool size |
| cfg_dir_size | input | POOL_W | Directed pool size override, 0 selects size/4 |
| cfg_depth | input | NUM_PORTS*DEPTH_W | Per-port enqueue depth, port i at bits [i*DEPTH_W +: DEPTH_W] |
| enq_req | input | NUM_PORTS | Per-port enqueue request |
| enq_dir | input | NUM_PORTS | Per-port request targets directed traffic |
| enq_ok | output | NUM_PORTS | Request accepted |
| enq_rej | output | NUM_PORTS | Request refused |
| ret_valid | input | 1 | Return one credit this cycle |
| ret_dir | input | 1 | Returned credit is directed |
| running | output | 1 | Configuration loaded |
| lb_level | output | POOL_W | Load-balanced shared pool level |
| dir_level | output | POOL_W | Directed shared pool level |
| lb_credit | output | NUM_PORTS*DEPTH_W | Per-port load-balanced credits |
| dir_credit | output | NUM_PORTS*DEPTH_W | Per-port directed credits |

## Verification
The bench drains a port down to exactly its low watermark and expects a refill one edge later. A comparison that is off by one would either refill a credit too early or leave the port starved. With a pool that sits just below one quantum, the bench feeds returns one at a time; a design that grants partial quanta or lets the level go negative shows a wrong credit count there. Four ports become needy at once, and the refill order is checked through a wrap-around, which exposes a fixed-priority arbiter or one whose pointer is not cleared on start. Dual-mode runs cross directed and load-balanced requests and returns to catch a pool mix-up, and also check the quarter-size default and the per-port directed cap.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

    localparam int DEPTH_W  = 8;
    localparam int LWM_CAP  = 16;

    typedef struct packed {
        logic [DEPTH_W-1:0] hwm;
        logic [DEPTH_W-1:0] quantum;
        logic [DEPTH_W-1:0] lwm;
    } port_wm_t;

    function automatic port_wm_t derive_wm(input logic [DEPTH_W-1:0] depth);
        port_wm_t w;
        w.hwm     = depth;
        w.quantum = depth >> 1;
        w.lwm     = (w.quantum < DEPTH_W'(LWM_CAP)) ? w.quantum : DEPTH_W'(LWM_CAP);
        return w;
    endfunction

endpackage

// File: rtl/cpm_rr_arb.sv
module cpm_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] next_ptr;
    logic             found;

    always_comb begin
        grant    = '0;
        found    = 1'b0;
        next_ptr = ptr_q;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr_q) + k) % N;
            if (!found && req[idx]) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                next_ptr   = PTR_W'((idx + 1) % N);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) ptr_q <= '0;
        else if (found)   ptr_q <= next_ptr;
    end

endmodule

// File: rtl/cpm_credit_slot.sv
module cpm_credit_slot
    import cpm_pkg::*;
#(
    parameter int POOL_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [DEPTH_W-1:0] hwm_in,
    input  logic               spend,
    input  logic               grant,
    input  logic [POOL_W-1:0]  pool_level,
    output logic [DEPTH_W-1:0] credit,
    output logic [DEPTH_W-1:0] hwm,
    output logic [DEPTH_W-1:0] quantum,
    output logic               need
);
    port_wm_t           wm_q;
    logic [DEPTH_W-1:0] cred_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wm_q   <= '0;
            cred_q <= '0;
        end else if (start) begin
            wm_q   <= derive_wm(hwm_in);
            cred_q <= hwm_in;
        end else begin
            cred_q <= cred_q - DEPTH_W'(spend) + (grant ? wm_q.quantum : '0);
        end
    end

    assign need    = (wm_q.quantum != '0) && (cred_q <= wm_q.lwm) &&
                     (pool_level >= POOL_W'(wm_q.quantum));
    assign credit  = cred_q;
    assign hwm     = wm_q.hwm;
    assign quantum = wm_q.quantum;

endmodule

// File: rtl/cpm_pool.sv
module cpm_pool
    import cpm_pkg::*;
#(
    parameter int N      = 4,
    parameter int POOL_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [POOL_W-1:0]    init_level,
    input  logic [N*DEPTH_W-1:0] hwm_in,
    input  logic [N-1:0]         spend,
    input  logic                 ret,
    output logic [N*DEPTH_W-1:0] credit_flat,
    output logic [N*DEPTH_W-1:0] hwm_flat,
    output logic [N-1:0]         has_credit,
    output logic [POOL_W-1:0]    level
);
    logic [POOL_W-1:0]  level_q;
    logic [N-1:0]       need;
    logic [N-1:0]       grant;
    logic [DEPTH_W-1:0] quantum [N];
    logic [POOL_W-1:0]  take;

    for (genvar i = 0; i < N; i++) begin : g_slot
        cpm_credit_slot #(.POOL_W(POOL_W)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .start      (start),
            .hwm_in     (hwm_in[i*DEPTH_W +: DEPTH_W]),
            .spend      (spend[i]),
            .grant      (grant[i]),
            .pool_level (level_q),
            .credit     (credit_flat[i*DEPTH_W +: DEPTH_W]),
            .hwm        (hwm_flat[i*DEPTH_W +: DEPTH_W]),
            .quantum    (quantum[i]),
            .need       (need[i])
        );
        assign has_credit[i] = credit_flat[i*DEPTH_W +: DEPTH_W] != '0;
    end

    cpm_rr_arb #(.N(N)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .clear (start),
        .req   (start ? '0 : need),
        .grant (grant)
    );

    always_comb begin
        take = '0;
        for (int i = 0; i < N; i++)
            if (grant[i]) take = POOL_W'(quantum[i]);
    end

    always_ff @(posedge clk) begin
        if (rst)        level_q <= '0;
        else if (start) level_q <= init_level;
        else            level_q <= level_q - take + POOL_W'(ret);
    end

    assign level = level_q;

endmodule

// File: rtl/credit_pool_mgr.sv
module credit_pool_mgr
    import cpm_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int POOL_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cfg_start,
    input  logic                         cfg_dual,
    input  logic [POOL_W-1:0]            cfg_pool_size,
    input  logic [POOL_W-1:0]            cfg_dir_size,
    input  logic [NUM_PORTS*DEPTH_W-1:0] cfg_depth,
    input  logic [NUM_PORTS-1:0]         enq_req,
    input  logic [NUM_PORTS-1:0]         enq_dir,
    output logic [NUM_PORTS-1:0]         enq_ok,
    output logic [NUM_PORTS-1:0]         enq_rej,
    input  logic                         ret_valid,
    input  logic                         ret_dir,
    output logic                         running,
    output logic [POOL_W-1:0]            lb_level,
    output logic [POOL_W-1:0]            dir_level,
    output logic [NUM_PORTS*DEPTH_W-1:0] lb_credit,
    output logic [NUM_PORTS*DEPTH_W-1:0] dir_credit
);
    localparam int N = NUM_PORTS;

    logic                 running_q;
    logic                 dual_q;
    logic [POOL_W-1:0]    dir_size;
    logic [POOL_W-1:0]    dir_share;
    logic [POOL_W-1:0]    lb_sum, dir_sum;
    logic [POOL_W-1:0]    lb_init, dir_init;
    logic [N*DEPTH_W-1:0] dir_hwm_cfg;
    logic [N*DEPTH_W-1:0] lb_hwm_flat, dir_hwm_flat;
    logic [N-1:0]         lb_has, dir_has;
    logic [N-1:0]         use_dir;
    logic [N-1:0]         lb_spend, dir_spend;

    // Configuration arithmetic for both pools
    always_comb begin
        dir_size  = (cfg_dir_size != '0) ? cfg_dir_size : (cfg_pool_size >> 2);
        dir_share = dir_size / POOL_W'(N);
        lb_sum    = '0;
        dir_sum   = '0;
        for (int i = 0; i < N; i++) begin
            logic [POOL_W-1:0] d;
            d = POOL_W'(cfg_depth[i*DEPTH_W +: DEPTH_W]);
            if (!cfg_dual)
                dir_hwm_cfg[i*DEPTH_W +: DEPTH_W] = '0;
            else if (d < dir_share)
                dir_hwm_cfg[i*DEPTH_W +: DEPTH_W] = d[DEPTH_W-1:0];
            else
                dir_hwm_cfg[i*DEPTH_W +: DEPTH_W] = dir_share[DEPTH_W-1:0];
            lb_sum  = lb_sum + d;
            dir_sum = dir_sum + POOL_W'(dir_hwm_cfg[i*DEPTH_W +: DEPTH_W]);
        end
        lb_init  = cfg_pool_size - lb_sum;
        dir_init = cfg_dual ? (dir_size - dir_sum) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            dual_q    <= 1'b0;
        end else if (cfg_start) begin
            running_q <= 1'b1;
            dual_q    <= cfg_dual;
        end
    end

    // Per-port accept / reject
    always_comb begin
        for (int i = 0; i < N; i++) begin
            use_dir[i]   = dual_q & enq_dir[i];
            enq_ok[i]    = running_q & enq_req[i] & (use_dir[i] ? dir_has[i] : lb_has[i]);
            enq_rej[i]   = enq_req[i] & ~enq_ok[i];
            lb_spend[i]  = enq_ok[i] & ~use_dir[i];
            dir_spend[i] = enq_ok[i] &  use_dir[i];
        end
    end

    cpm_pool #(.N(N), .POOL_W(POOL_W)) u_lb (
        .clk         (clk),
        .rst         (rst),
        .start       (cfg_start),
        .init_level  (lb_init),
        .hwm_in      (cfg_depth),
        .spend       (lb_spend),
        .ret         (ret_valid & ~(dual_q & ret_dir)),
        .credit_flat (lb_credit),
        .hwm_flat    (lb_hwm_flat),
        .has_credit  (lb_has),
        .level       (lb_level)
    );

    cpm_pool #(.N(N), .POOL_W(POOL_W)) u_dir (
        .clk         (clk),
        .rst         (rst),
        .start       (cfg_start),
        .init_level  (dir_init),
        .hwm_in      (dir_hwm_cfg),
        .spend       (dir_spend),
        .ret         (ret_valid & dual_q & ret_dir),
        .credit_flat (dir_credit),
        .hwm_flat    (dir_hwm_flat),
        .has_credit  (dir_has),
        .level       (dir_level)
    );

    assign running = running_q;

endmodule

// File: rtl/credit_pool_mgr_chk.sv
module credit_pool_mgr_chk
    import cpm_pkg::*;
#(
    parameter int N = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cfg_start,
    input logic [N*DEPTH_W-1:0] cfg_depth,
    input logic                 running,
    input logic                 dual_q,
    input logic [N-1:0]         enq_req,
    input logic [N-1:0]         enq_dir,
    input logic [N-1:0]         enq_ok,
    input logic [N-1:0]         enq_rej,
    input logic [N*DEPTH_W-1:0] lb_credit,
    input logic [N*DEPTH_W-1:0] dir_credit,
    input logic [N*DEPTH_W-1:0] lb_hwm_flat,
    input logic [N*DEPTH_W-1:0] dir_hwm_flat
);
    // R1
    idle_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        !running |-> enq_ok == '0);

    for (genvar i = 0; i < N; i++) begin : g_port
        // R8
        lb_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            lb_credit[i*DEPTH_W +: DEPTH_W] <= lb_hwm_flat[i*DEPTH_W +: DEPTH_W]);
        // R8
        dir_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
            dir_credit[i*DEPTH_W +: DEPTH_W] <= dir_hwm_flat[i*DEPTH_W +: DEPTH_W]);
        // R3
        one_answer_chk: assert property (@(posedge clk) disable iff (rst)
            enq_req[i] |-> $onehot({enq_ok[i], enq_rej[i]}));
        // R4
        empty_reject_chk: assert property (@(posedge clk) disable iff (rst)
            (running && enq_req[i] && !(dual_q && enq_dir[i]) &&
             lb_credit[i*DEPTH_W +: DEPTH_W] == '0) |-> enq_rej[i]);
        // R2
        precharge_chk: assert property (@(posedge clk) disable iff (rst)
            $past(cfg_start) |-> lb_credit[i*DEPTH_W +: DEPTH_W] ==
                                 $past(cfg_depth[i*DEPTH_W +: DEPTH_W]));
    end

endmodule

bind credit_pool_mgr credit_pool_mgr_chk #(.N(NUM_PORTS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_start    (cfg_start),
    .cfg_depth    (cfg_depth),
    .running      (running),
    .dual_q       (dual_q),
    .enq_req      (enq_req),
    .enq_dir      (enq_dir),
    .enq_ok       (enq_ok),
    .enq_rej      (enq_rej),
    .lb_credit    (lb_credit),
    .dir_credit   (dir_credit),
    .lb_hwm_flat  (lb_hwm_flat),
    .dir_hwm_flat (dir_hwm_flat)
);

// File: tb/credit_pool_mgr_bench.sv
`timescale 1ns/1ps
module credit_pool_mgr_bench;
    import cpm_pkg::*;

    localparam int N  = 4;
    localparam int PW = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_start, cfg_dual;
    logic [PW-1:0]     cfg_pool_size, cfg_dir_size;
    logic [N*DEPTH_W-1:0] cfg_depth;
    logic [N-1:0]      enq_req, enq_dir, enq_ok, enq_rej;
    logic              ret_valid, ret_dir, running;
    logic [PW-1:0]     lb_level, dir_level;
    logic [N*DEPTH_W-1:0] lb_credit, dir_credit;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    always #2.5 clk = ~clk;

    credit_pool_mgr #(.NUM_PORTS(N), .POOL_W(PW)) u_credit_pool_mgr (
        .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_dual(cfg_dual),
        .cfg_pool_size(cfg_pool_size), .cfg_dir_size(cfg_dir_size),
        .cfg_depth(cfg_depth), .enq_req(enq_req), .enq_dir(enq_dir),
        .enq_ok(enq_ok), .enq_rej(enq_rej), .ret_valid(ret_valid),
        .ret_dir(ret_dir), .running(running), .lb_level(lb_level),
        .dir_level(dir_level), .lb_credit(lb_credit), .dir_credit(dir_credit)
    );

    function automatic int lbc(int p);
        return int'(lb_credit[p*DEPTH_W +: DEPTH_W]);
    endfunction
    function automatic int dirc(int p);
        return int'(dir_credit[p*DEPTH_W +: DEPTH_W]);
    endfunction

    task automatic chk(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_cfg(bit dual, int pool, int dsz, int depth);
        cfg_dual      = dual;
        cfg_pool_size = PW'(pool);
        cfg_dir_size  = PW'(dsz);
        for (int i = 0; i < N; i++) cfg_depth[i*DEPTH_W +: DEPTH_W] = DEPTH_W'(depth);
        cfg_start = 1'b1;
        tick(1);
        cfg_start = 1'b0;
    endtask

    task automatic enq(logic [N-1:0] ports, logic [N-1:0] dir, int n);
        enq_req = ports;
        enq_dir = dir;
        tick(n);
        enq_req = '0;
        enq_dir = '0;
    endtask

    task automatic give_back(bit dir, int n);
        ret_valid = 1'b1;
        ret_dir   = dir;
        tick(n);
        ret_valid = 1'b0;
        ret_dir   = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 running", int'(running), 0);
        chk("R1 lb_level", int'(lb_level), 0);
        chk("R1 credit0", lbc(0), 0);
        enq_req = 4'b0001;
        #1;
        chk("R1 reject before start", int'(enq_rej[0]), 1);
        chk("R1 no accept before start", int'(enq_ok[0]), 0);
        enq_req = '0;
        tick(1);
    endtask

    task automatic t_start_spend_refill;
        start_cfg(1'b0, 4096, 0, 32);
        chk("R2 lb_level", int'(lb_level), 3968);
        for (int p = 0; p < N; p++) chk("R2 precharge", lbc(p), 32);
        enq_req = 4'b0001;
        #1;
        chk("R3 same-cycle accept", int'(enq_ok[0]), 1);
        tick(1);
        enq_req = '0;
        chk("R3 credit minus one", lbc(0), 31);
        chk("R3 pool unchanged", int'(lb_level), 3968);
        enq(4'b0001, 4'b0000, 15);
        chk("R5 at low watermark", lbc(0), 16);
        tick(1);
        chk("R5 refilled", lbc(0), 32);
        chk("R5 pool less quantum", int'(lb_level), 3952);
        give_back(1'b1, 1);
        chk("R9 single-mode return to lb", int'(lb_level), 3953);
        chk("R11 single-mode dir pool zero", int'(dir_level), 0);
        enq(4'b0010, 4'b0010, 1);
        chk("R11 single mode dir ignored", lbc(1), 31);
        chk("R11 single mode dir credit", dirc(1), 0);
    endtask

    task automatic t_reject_defer;
        start_cfg(1'b0, 16, 0, 4);
        chk("R2 empty pool", int'(lb_level), 0);
        enq(4'b0001, 4'b0000, 4);
        chk("R6 drained no refill", lbc(0), 0);
        enq_req = 4'b0001;
        #1;
        chk("R4 reject at zero", int'(enq_rej[0]), 1);
        tick(1);
        enq_req = '0;
        chk("R4 credit stays zero", lbc(0), 0);
        chk("R4 pool untouched", int'(lb_level), 0);
        give_back(1'b0, 1);
        tick(1);
        chk("R6 deferred below quantum", lbc(0), 0);
        chk("R6 pool holds one", int'(lb_level), 1);
        give_back(1'b0, 1);
        tick(1);
        chk("R6 refill after returns", lbc(0), 2);
        chk("R6 pool consumed", int'(lb_level), 0);
    endtask

    task automatic t_round_robin;
        start_cfg(1'b0, 16, 0, 4);
        enq(4'b1111, 4'b0000, 2);
        for (int p = 0; p < N; p++) chk("R7 all needy", lbc(p), 2);
        for (int p = 0; p < 3; p++) begin
            give_back(1'b0, 2);
            tick(1);
            chk("R7 granted in order", lbc(p), 4);
            chk("R7 last still waiting", lbc(3), 2);
        end
        enq(4'b0001, 4'b0000, 2);
        give_back(1'b0, 2);
        tick(1);
        chk("R7 pointer continues to 3", lbc(3), 4);
        chk("R7 port0 waits", lbc(0), 2);
        give_back(1'b0, 2);
        tick(1);
        chk("R7 wrap to 0", lbc(0), 4);
    endtask

    task automatic t_dual;
        start_cfg(1'b1, 4096, 0, 32);
        chk("R10 default dir credit", dirc(2), 32);
        chk("R10 default dir pool", int'(dir_level), 896);
        chk("R10 lb pool", int'(lb_level), 3968);
        start_cfg(1'b1, 4096, 40, 32);
        chk("R10 capped dir credit", dirc(1), 10);
        chk("R10 override dir pool", int'(dir_level), 0);
        enq(4'b0010, 4'b0010, 1);
        chk("R11 dir spends dir", dirc(1), 9);
        chk("R11 dir leaves lb", lbc(1), 32);
        enq(4'b0010, 4'b0000, 1);
        chk("R11 lb spends lb", lbc(1), 31);
        chk("R11 lb leaves dir", dirc(1), 9);
        enq(4'b0010, 4'b0010, 4);
        tick(1);
        chk("R6 dir waits for pool", dirc(1), 5);
        give_back(1'b1, 5);
        chk("R9 lb pool unchanged by dir return", int'(lb_level), 3968);
        tick(1);
        chk("R5 dir refilled", dirc(1), 10);
        chk("R5 dir pool drained", int'(dir_level), 0);
        give_back(1'b0, 1);
        chk("R9 lb return in dual", int'(lb_level), 3969);
    endtask

    initial begin
        rst = 1'b1; cfg_start = 0; cfg_dual = 0; cfg_pool_size = '0;
        cfg_dir_size = '0; cfg_depth = '0; enq_req = '0; enq_dir = '0;
        ret_valid = 0; ret_dir = 0;
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_start_spend_refill();
        t_reject_defer();
        t_round_robin();
        t_dual();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule